// File: doc/BRIEF.md
# Host Strobe Ready-Timing Controller

This block sits on the host-bus side of a speech processor. It watches two active-low strobes from the host, one for reads and one for writes, and drives an active-low ready handshake back to the host. When either strobe falls, ready is withdrawn (driven high) and held high for a number of clocks. The number depends on the kind of access. A read holds for one length. A write while the processor accepts external speech data (FIFO mode) holds for a second length. A write in command mode holds for a length chosen from the command code in the data bus field at bits 6:4. When the hold ends, ready returns low and a one-cycle done pulse is issued. The command itself is executed elsewhere.

Both strobes pass through a two-flop synchronizer before edge detection. A controller with three states schedules the hold. ST_IDLE has ready active. ST_HOLD has ready withdrawn while a down-counter runs. ST_RELEASE has ready active again and raises the done pulse for one cycle.

The transitions are as follows. ST_IDLE goes to ST_HOLD on any detected strobe fall. ST_HOLD reloads and stays in ST_HOLD on a new fall. It goes to ST_RELEASE when the counter is zero. Otherwise it stays and counts. ST_RELEASE goes to ST_HOLD on a fall and otherwise returns to ST_IDLE.

Top module: `host_ready_timer`

## Requirements
- R1: While reset is asserted, and after it is released with no strobe activity, ready_n is 0 (active) and ready_done is 0.
- R2: If a strobe is first sampled low at clock edge k while the block is idle, ready_n is still 0 after edge k+1 and is 1 after edge k+2.
- R3: A read-strobe fall holds ready_n at 1 for exactly READ_HOLD clocks (default 16).
- R4: A write-strobe fall with ext_mode=1 holds ready_n at 1 for exactly FIFO_HOLD clocks (default 16), whatever the command field holds.
- R5: A write-strobe fall with ext_mode=0 and command field host_data[6:4] equal to 3'b011 (branch-when-ready) or 3'b111 (clear) holds ready_n at 1 for 100 clocks (BRANCH_HOLD, CLEAR_HOLD).
- R6: A command-mode write with host_data[6:4]=3'b001 (read byte) holds ready_n at 1 for 80 clocks (BYTE_HOLD).
- R7: A command-mode write with host_data[6:4]=3'b010 (rate set) holds for RATE_HOLD (16) clocks; every other code holds for OTHER_HOLD (16) clocks.
- R8: ready_done is 1 for exactly one cycle: the first cycle in which ready_n is back at 0 after a hold. It is 0 at all other times.
- R9: A strobe fall detected during a hold restarts the count with the length of the new access, so the combined inactive time is the time up to the new load plus the new length.
- R10: If both strobes fall in the same cycle, the write length is used.
- R11: Only host_data[6:4] and ext_mode in the cycle the fall is detected select the length. Other data bits, and changes after that cycle, have no effect.
- R12: A strobe held low for longer than the hold produces a single hold. The hold is not retriggered while the strobe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb_n | input | 1 | Host read strobe, active low, asynchronous |
| wr_stb_n | input | 1 | Host write strobe, active low, asynchronous |
| host_data | input | 8 | Host data bus; bits 6:4 carry the command code |
| ext_mode | input | 1 | 1 = writes go to the external speech FIFO; 0 = writes are commands |
| ready_n | output | 1 | Ready handshake, active low |
| ready_done | output | 1 | One-cycle pulse when ready returns active |

## Verification
Three register stages lie between a strobe and ready_n: two synchronizer flops and the state register. ready_n therefore rises after the third clock edge that sees the strobe low. The bench samples on falling edges. It checks ready_n low at the second falling edge after driving the strobe and high at the third.

A hold of N clocks shows as exactly N falling-edge samples with ready_n high. The done pulse must coincide with the first low sample that follows. The driver queues the expected high-time of each access. For a restart, the queued value is the offset of the second strobe plus the second length. The monitor counts high samples and compares each count when ready_n falls.

// File: rtl/host_ready_pkg.sv
package host_ready_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_HOLD    = 2'd1,
        ST_RELEASE = 2'd2
    } rdy_state_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_FIFO  = 2'd1,
        ACC_CMD   = 2'd2
    } rdy_access_e;

    localparam int          CMD_W      = 3;
    localparam int          CMD_LSB    = 4;
    localparam logic [2:0]  CMD_BYTE   = 3'b001;
    localparam logic [2:0]  CMD_RATE   = 3'b010;
    localparam logic [2:0]  CMD_BRANCH = 3'b011;
    localparam logic [2:0]  CMD_CLEAR  = 3'b111;

    function automatic int max_of2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/host_strobe_sync.sv
module host_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strb_n,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], strb_n};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign fall = prev_q & ~sync_q[STAGES-1];

    // One detected edge per strobe fall, never two in a row
    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall); // R12

endmodule

// File: rtl/host_hold_select.sv
module host_hold_select
    import host_ready_pkg::*;
#(
    parameter int CNT_W       = 7,
    parameter int READ_HOLD   = 16,
    parameter int FIFO_HOLD   = 16,
    parameter int BRANCH_HOLD = 100,
    parameter int CLEAR_HOLD  = 100,
    parameter int BYTE_HOLD   = 80,
    parameter int RATE_HOLD   = 16,
    parameter int OTHER_HOLD  = 16
) (
    input  logic             is_write,
    input  logic             ext,
    input  logic [CMD_W-1:0] cmd,
    output logic [CNT_W-1:0] len_m1
);
    rdy_access_e kind;

    always_comb begin
        if (!is_write)
            kind = ACC_READ;
        else if (ext)
            kind = ACC_FIFO;
        else
            kind = ACC_CMD;
    end

    always_comb begin
        unique case (kind)
            ACC_READ: len_m1 = CNT_W'(READ_HOLD - 1);
            ACC_FIFO: len_m1 = CNT_W'(FIFO_HOLD - 1);
            default: begin
                unique case (cmd)
                    CMD_BRANCH: len_m1 = CNT_W'(BRANCH_HOLD - 1);
                    CMD_CLEAR:  len_m1 = CNT_W'(CLEAR_HOLD - 1);
                    CMD_BYTE:   len_m1 = CNT_W'(BYTE_HOLD - 1);
                    CMD_RATE:   len_m1 = CNT_W'(RATE_HOLD - 1);
                    default:    len_m1 = CNT_W'(OTHER_HOLD - 1);
                endcase
            end
        endcase
    end

endmodule

// File: rtl/host_hold_counter.sv
module host_hold_counter #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (step && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // A load followed by no further events reaches zero only through steps
    AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> !zero); // R3

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !zero) |=> cnt_q == $past(cnt_q) - 1'b1); // R3

endmodule

// File: rtl/host_ready_timer.sv
module host_ready_timer
    import host_ready_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int READ_HOLD   = 16,
    parameter int FIFO_HOLD   = 16,
    parameter int BRANCH_HOLD = 100,
    parameter int CLEAR_HOLD  = 100,
    parameter int BYTE_HOLD   = 80,
    parameter int RATE_HOLD   = 16,
    parameter int OTHER_HOLD  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb_n,
    input  logic              wr_stb_n,
    input  logic [DATA_W-1:0] host_data,
    input  logic              ext_mode,
    output logic              ready_n,
    output logic              ready_done
);
    localparam int HOLD_MAX = max_of2(max_of2(max_of2(READ_HOLD, FIFO_HOLD),
                                              max_of2(BRANCH_HOLD, CLEAR_HOLD)),
                                      max_of2(max_of2(BYTE_HOLD, RATE_HOLD), OTHER_HOLD));
    localparam int CNT_W    = (HOLD_MAX > 2) ? $clog2(HOLD_MAX) : 1;
    localparam int N_STB    = 2;

    logic [N_STB-1:0] stb_raw;
    logic [N_STB-1:0] stb_fall;
    logic [CNT_W-1:0] len_m1 [N_STB];
    logic [CNT_W-1:0] load_val;
    logic             any_fall;
    logic             cnt_zero;
    logic             cnt_step;
    logic [CMD_W-1:0] cmd_field;
    logic             unused_bits;

    rdy_state_e state_q, state_d;

    assign stb_raw     = {wr_stb_n, rd_stb_n};
    assign cmd_field   = host_data[CMD_LSB +: CMD_W];
    assign unused_bits = ^{host_data[DATA_W-1:CMD_LSB+CMD_W], host_data[CMD_LSB-1:0]};

    // index 0 = read strobe, index 1 = write strobe
    for (genvar g = 0; g < N_STB; g++) begin : g_stb
        host_strobe_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .strb_n (stb_raw[g]),
            .fall   (stb_fall[g])
        );

        host_hold_select #(
            .CNT_W       (CNT_W),
            .READ_HOLD   (READ_HOLD),
            .FIFO_HOLD   (FIFO_HOLD),
            .BRANCH_HOLD (BRANCH_HOLD),
            .CLEAR_HOLD  (CLEAR_HOLD),
            .BYTE_HOLD   (BYTE_HOLD),
            .RATE_HOLD   (RATE_HOLD),
            .OTHER_HOLD  (OTHER_HOLD)
        ) u_sel (
            .is_write (1'(g)),
            .ext      (ext_mode),
            .cmd      (cmd_field),
            .len_m1   (len_m1[g])
        );
    end

    assign any_fall = |stb_fall;
    // write access takes priority when both strobes fall together
    assign load_val = stb_fall[1] ? len_m1[1] : len_m1[0];
    assign cnt_step = (state_q == ST_HOLD);

    host_hold_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (any_fall),
        .load_val (load_val),
        .step     (cnt_step),
        .zero     (cnt_zero)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (any_fall) state_d = ST_HOLD;
            ST_HOLD: begin
                if (any_fall)      state_d = ST_HOLD;
                else if (cnt_zero) state_d = ST_RELEASE;
            end
            ST_RELEASE: state_d = any_fall ? ST_HOLD : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        ready_n    = (state_q == ST_HOLD);
        ready_done = (state_q == ST_RELEASE);
    end

    AST_FALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        any_fall |=> ready_n); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ready_done |=> !ready_done); // R8

    AST_DONE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ready_done |-> ($past(ready_n) && !ready_n)); // R8

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_fall[0] && stb_fall[1]) |-> load_val == len_m1[1]); // R10

    AST_READ_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_fall[0] && !stb_fall[1]) |-> load_val == CNT_W'(READ_HOLD - 1)); // R3

endmodule

// File: tb/host_ready_timer_test.sv
module host_ready_timer_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rd_stb_n;
    logic       wr_stb_n;
    logic [7:0] host_data;
    logic       ext_mode;
    logic       ready_n;
    logic       ready_done;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    bit mon_on = 1'b0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    host_ready_timer uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_stb_n   (rd_stb_n),
        .wr_stb_n   (wr_stb_n),
        .host_data  (host_data),
        .ext_mode   (ext_mode),
        .ready_n    (ready_n),
        .ready_done (ready_done)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one access; strobe low for 'low' cycles (>=3). Pushes 'exp_len' if > 0.
    task automatic drive(input bit rd, input bit wr, input logic [7:0] d, input bit ext,
                         input int low, input int exp_len, input bit check_lat, input string req);
        @(negedge clk);
        host_data = d;
        ext_mode  = ext;
        if (rd) rd_stb_n = 1'b0;
        if (wr) wr_stb_n = 1'b0;
        if (exp_len > 0) exp_q.push_back(exp_len);
        repeat (2) @(negedge clk);
        if (check_lat) chk({"R2 still ready ", req}, int'(ready_n), 0);
        @(negedge clk);
        if (check_lat) chk({"R2 withdrawn ", req}, int'(ready_n), 1);
        repeat (low - 3) @(negedge clk);
        rd_stb_n = 1'b1;
        wr_stb_n = 1'b1;
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Monitor: count high samples of ready_n, compare on each return to low
    initial begin : monitor
        int  hi_cnt = 0;
        bit  prev   = 1'b0;
        forever begin
            @(negedge clk);
            if (mon_on) begin
                if (ready_n) hi_cnt++;
                if (prev && !ready_n) begin
                    if (exp_q.size() == 0) begin
                        chk("R12 unexpected hold", hi_cnt, 0);
                    end else begin
                        chk("R3-R7/R9 hold length", hi_cnt, exp_q.pop_front());
                    end
                    chk("R8 done with release", int'(ready_done), 1);
                    hi_cnt = 0;
                end else if (ready_done) begin
                    chk("R8 stray done", int'(ready_done), 0);
                end
                prev = ready_n;
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stimulus
        rst_n     = 1'b0;
        rd_stb_n  = 1'b1;
        wr_stb_n  = 1'b1;
        host_data = 8'h00;
        ext_mode  = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1 ready in reset", int'(ready_n), 0);
        chk("R1 done in reset", int'(ready_done), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 ready after reset", int'(ready_n), 0);
        chk("R1 done after reset", int'(ready_done), 0);
        mon_on = 1'b1;

        // R3: read
        drive(1, 0, 8'h00, 0, 3, 16, 1, "R3 read");
        wait_idle();
        // R4: FIFO write ignores command field
        drive(0, 1, 8'h70, 1, 3, 16, 1, "R4 fifo");
        wait_idle();
        // R5: branch-when-ready and clear
        drive(0, 1, 8'h30, 0, 3, 100, 1, "R5 branch");
        wait_idle();
        drive(0, 1, 8'h70, 0, 3, 100, 1, "R5 clear");
        wait_idle();
        // R6: read byte
        drive(0, 1, 8'h10, 0, 3, 80, 1, "R6 byte");
        wait_idle();
        // R7: rate set and an undefined code
        drive(0, 1, 8'h20, 0, 3, 16, 1, "R7 rate");
        wait_idle();
        drive(0, 1, 8'h40, 0, 3, 16, 1, "R7 other");
        wait_idle();
        // R11: other bits set, field changed after sampling
        drive(0, 1, 8'h9F, 0, 3, 80, 1, "R11 field");
        host_data = 8'h70;
        ext_mode  = 1'b1;
        wait_idle();
        ext_mode  = 1'b0;
        // R10: both strobes together, write length wins
        drive(1, 1, 8'h70, 0, 3, 100, 1, "R10 both");
        wait_idle();
        // R9: read then read-byte write 8 cycles later -> 8 + 80
        drive(1, 0, 8'h00, 0, 3, 88, 1, "R9 first");
        repeat (4) @(negedge clk);
        drive(0, 1, 8'h10, 0, 3, 0, 0, "R9 second");
        wait_idle();
        // R12: long strobe, single hold, nothing afterwards
        drive(1, 0, 8'h00, 0, 40, 16, 1, "R12 long");
        wait_idle();
        repeat (30) @(negedge clk);
        chk("R12 idle after long strobe", int'(ready_n), 0);
        chk("R12 queue drained", exp_q.size(), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule